// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a virtual page number into a physical page by walking a two-level table of 32-bit entries held in memory. It accepts one request at a time (virtual page, page offset, write flag) and fetches a first-level entry. If that entry is valid, it then fetches a second-level entry. It presents the physical page, the physical byte address, the write permission and the page-size code on a result port for one cycle. Memory is reached through a plain read port: a one-cycle request pulse with a word address, and a response strobe with data that may come any number of cycles later. Only one read is ever in flight.

Each table page is 4 KiB and holds 1024 four-byte entries, so one second-level page maps 4 MiB. The first-level entry is found by adding the upper virtual page bits, in word units, to a configured table base page. Software biases that base downward so the translated window need not start at address zero. An entry whose valid bit is clear sends the access to a configurable illegal page, or to page zero when the illegal page is disabled. A write through an entry without write permission is flagged. Both conditions also set sticky flags, which are cleared by pulsing a clear input. While the single-table mode input is high, the walker accepts no request.

Top module: `xlat_walker`

## Requirements
- R1: During reset and just after it, req_ready is 1 (with cfg_single low), while mem_req_valid, res_valid, flag_inv and flag_wv are all 0.
- R2: For each accepted request, the first memory read has word address cfg_base_ppn*1024 + req_vpn[VPN_W-1:10]. The add carries, so a small biased base with a large index still works.
- R3: When the first-level entry has bit 28 (valid) set, a second read follows at word address {entry[27:0], req_vpn[9:0]}. Bits 31:29 of the first-level entry have no effect on the result.
- R4: A second-level entry with bit 28 set gives res_ppn = entry[27:0], res_writable = entry[29] and res_size = entry[31:30]. It also gives res_paddr = {res_ppn, req_off} and res_inv = 0. res_valid is high for exactly one cycle per request.
- R5: A first-level entry with bit 28 clear (including all zero) ends the walk after that single read with res_inv = 1. res_ppn is then cfg_ill_ppn when cfg_ill_en is 1, and res_writable and res_size are 0.
- R6: A second-level entry with bit 28 clear gives res_inv = 1, even if other bits are set. res_ppn is then cfg_ill_ppn when cfg_ill_en is 1 and 0 when it is 0.
- R7: res_wv is 1 only for a write request through a valid second-level entry with bit 29 clear. A read through such an entry, or any access that ends invalid, gives res_wv = 0.
- R8: flag_inv and flag_wv become 1 in the cycle after a result with res_inv or res_wv and hold until a cycle with clr_inv_flag or clr_wv_flag high. Setting wins over clearing in the same cycle.
- R9: While cfg_single is 1, req_ready is 0 and no memory read is issued for a waiting request.
- R10: Only one memory read is outstanding: mem_req_valid is a one-cycle pulse, and req_ready is 0 from acceptance until the result cycle has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_ppn | input | PPN_W | Biased page number of the first-level table |
| cfg_single | input | 1 | Single-table mode; blocks all walks when 1 |
| cfg_ill_en | input | 1 | Redirect invalid accesses to cfg_ill_ppn |
| cfg_ill_ppn | input | PPN_W | Illegal page number |
| clr_inv_flag | input | 1 | Clear pulse for flag_inv |
| clr_wv_flag | input | 1 | Clear pulse for flag_wv |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | 12 | Byte offset inside the page |
| req_write | input | 1 | Request is a write |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | PPN_W+10 | Word address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry |
| res_valid | output | 1 | Result present for one cycle |
| res_ppn | output | PPN_W | Physical page number |
| res_paddr | output | PPN_W+12 | Physical byte address |
| res_writable | output | 1 | Page is writable |
| res_size | output | 2 | Page-size code (0 4 KiB, 1 big, 2 super, 3 4 MiB) |
| res_inv | output | 1 | Entry was invalid; access redirected |
| res_wv | output | 1 | Write to a read-only page |
| flag_inv | output | 1 | Sticky invalid-entry flag |
| flag_wv | output | 1 | Sticky write-violation flag |

## Verification
A wrong walk state shows up at the memory port within one cycle of the response that caused it. The bench compares every read address against a queue of expected addresses, so a missing second read, an extra one, or one issued with the wrong index fails on the clock where it appears. A badly captured request or a wrong entry decode shows up in the single result cycle as a wrong page, permission, size or fault bit. Flag corruption shows up one cycle later, where the bench samples the sticky outputs after each walk and after each clear.

// File: rtl/xw_pkg.sv
// Shared constants and types for the two-level translation walker.
// Assumes 4 KiB pages and 32-bit table entries (1024 per table page).
package xw_pkg;
    localparam int PG_SHIFT  = 12;
    localparam int IDX_W     = 10;
    localparam int ENTRY_W   = 32;
    localparam int FLD_PPN_W = 28;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2,
        ST_DONE = 2'd3
    } walk_state_t;

    // Entry layout: size code 31:30, writable 29, valid 28, page 27:0
    typedef struct packed {
        logic [1:0]           size;
        logic                 wr_ok;
        logic                 valid;
        logic [FLD_PPN_W-1:0] ppn;
    } pte_t;
endpackage

// File: rtl/xw_addr_gen.sv
// Forms the word addresses of both table reads.
// Assumes the base page is already biased by the aperture start.
module xw_addr_gen
    import xw_pkg::*;
#(
    parameter int VPN_W = 24,
    parameter int PPN_W = 28,
    localparam int AW   = PPN_W + IDX_W
) (
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [VPN_W-1:0] new_vpn,
    input  logic [IDX_W-1:0] walk_low,
    input  logic [PPN_W-1:0] l2_page,
    output logic [AW-1:0]    l1_addr,
    output logic [AW-1:0]    l2_addr
);
    localparam int HI_W = VPN_W - IDX_W;

    // First level: base page in words plus the upper page index
    always_comb begin
        l1_addr = {base_ppn, {IDX_W{1'b0}}} + AW'(new_vpn[VPN_W-1:IDX_W]);
    end

    // Second level: page from the first entry, indexed by the low page bits
    always_comb begin
        l2_addr = {l2_page, walk_low};
    end

    initial begin
        if (HI_W < 1) $error("VPN_W must exceed the table index width");
    end
endmodule

// File: rtl/xw_sticky.sv
// Holds the invalid-entry and write-violation flags until cleared.
// Assumes set and clear arrive as single-cycle strobes; set wins.
module xw_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_inv,
    input  logic set_wv,
    input  logic clr_inv,
    input  logic clr_wv,
    output logic flag_inv,
    output logic flag_wv
);
    // Update both flags: clear first, then let a new event win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_inv <= 1'b0;
            flag_wv  <= 1'b0;
        end else begin
            flag_inv <= (flag_inv & ~clr_inv) | set_inv;
            flag_wv  <= (flag_wv & ~clr_wv) | set_wv;
        end
    end

    // R8
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_inv && !clr_inv |=> flag_inv);
    // R8
    wv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wv && !clr_wv |=> flag_wv);
    // R8
    inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_inv && !set_inv |=> !flag_inv);
    // R8
    wv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wv |=> flag_wv);
endmodule

// File: rtl/xw_fsm.sv
// Walk controller: accepts a request, issues one table read at a time,
// decodes entries and registers the result for one cycle.
// Assumes the memory returns exactly one response per request pulse.
module xw_fsm
    import xw_pkg::*;
#(
    parameter int VPN_W = 24,
    parameter int PPN_W = 28,
    localparam int AW   = PPN_W + IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_single,
    input  logic                     cfg_ill_en,
    input  logic [PPN_W-1:0]         cfg_ill_ppn,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VPN_W-1:0]         req_vpn,
    input  logic [PG_SHIFT-1:0]      req_off,
    input  logic                     req_write,
    input  logic [AW-1:0]            l1_addr,
    input  logic [AW-1:0]            l2_addr,
    output logic [IDX_W-1:0]         walk_low,
    output logic [PPN_W-1:0]         walk_page,
    output logic                     mem_req_valid,
    output logic [AW-1:0]            mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [ENTRY_W-1:0]       mem_rsp_data,
    output logic                     res_valid,
    output logic [PPN_W-1:0]         res_ppn,
    output logic [PPN_W+PG_SHIFT-1:0] res_paddr,
    output logic                     res_writable,
    output logic [1:0]               res_size,
    output logic                     res_inv,
    output logic                     res_wv
);
    walk_state_t         state;
    logic [IDX_W-1:0]    low_q;
    logic [PG_SHIFT-1:0] off_q;
    logic                wr_q;
    pte_t                pte;
    logic                accept;
    logic [PPN_W-1:0]    c_ppn;
    logic                c_wr_ok;
    logic [1:0]          c_size;
    logic                c_inv;
    logic                c_wv;

    // Entry view of the returned data and handshake decode
    always_comb begin
        pte       = pte_t'(mem_rsp_data);
        walk_page = pte.ppn[PPN_W-1:0];
        walk_low  = low_q;
        req_ready = (state == ST_IDLE) && !cfg_single;
        accept    = req_valid && req_ready;
    end

    // Candidate result if the current response ends the walk
    always_comb begin
        c_inv   = !pte.valid;
        c_ppn   = pte.valid ? pte.ppn[PPN_W-1:0]
                            : (cfg_ill_en ? cfg_ill_ppn : '0);
        c_wr_ok = pte.valid && pte.wr_ok;
        c_size  = pte.valid ? pte.size : 2'd0;
        c_wv    = pte.valid && wr_q && !pte.wr_ok;
    end

    // Walk sequencing, memory request pulse and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            low_q         <= '0;
            off_q         <= '0;
            wr_q          <= 1'b0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            res_ppn       <= '0;
            res_writable  <= 1'b0;
            res_size      <= 2'd0;
            res_inv       <= 1'b0;
            res_wv        <= 1'b0;
        end else begin
            mem_req_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        low_q         <= req_vpn[IDX_W-1:0];
                        off_q         <= req_off;
                        wr_q          <= req_write;
                        mem_req_valid <= 1'b1;
                        mem_req_addr  <= l1_addr;
                        state         <= ST_L1;
                    end
                end
                ST_L1: begin
                    if (mem_rsp_valid) begin
                        if (pte.valid) begin
                            mem_req_valid <= 1'b1;
                            mem_req_addr  <= l2_addr;
                            state         <= ST_L2;
                        end else begin
                            res_ppn      <= c_ppn;
                            res_writable <= c_wr_ok;
                            res_size     <= c_size;
                            res_inv      <= c_inv;
                            res_wv       <= 1'b0;
                            state        <= ST_DONE;
                        end
                    end
                end
                ST_L2: begin
                    if (mem_rsp_valid) begin
                        res_ppn      <= c_ppn;
                        res_writable <= c_wr_ok;
                        res_size     <= c_size;
                        res_inv      <= c_inv;
                        res_wv       <= c_wv;
                        state        <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result strobe and byte address
    always_comb begin
        res_valid = (state == ST_DONE);
        res_paddr = {res_ppn, off_q};
    end

    // R10
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    // R9
    single_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_single && state == ST_IDLE) |=> !mem_req_valid);
    // R4
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R7
    wv_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_wv) |-> (!res_writable && !res_inv));
    // R5
    inv_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_inv) |-> (res_size == 2'd0 && !res_writable));
endmodule

// File: rtl/xlat_walker.sv
// Top of the two-level translation walker: address forming, walk
// control and sticky fault flags. Assumes PPN_W <= 28 and VPN_W > 10.
module xlat_walker
    import xw_pkg::*;
#(
    parameter int VPN_W = 24,
    parameter int PPN_W = 28,
    localparam int AW   = PPN_W + IDX_W,
    localparam int PA_W = PPN_W + PG_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PPN_W-1:0]    cfg_base_ppn,
    input  logic                cfg_single,
    input  logic                cfg_ill_en,
    input  logic [PPN_W-1:0]    cfg_ill_ppn,
    input  logic                clr_inv_flag,
    input  logic                clr_wv_flag,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VPN_W-1:0]    req_vpn,
    input  logic [PG_SHIFT-1:0] req_off,
    input  logic                req_write,
    output logic                mem_req_valid,
    output logic [AW-1:0]       mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [ENTRY_W-1:0]  mem_rsp_data,
    output logic                res_valid,
    output logic [PPN_W-1:0]    res_ppn,
    output logic [PA_W-1:0]     res_paddr,
    output logic                res_writable,
    output logic [1:0]          res_size,
    output logic                res_inv,
    output logic                res_wv,
    output logic                flag_inv,
    output logic                flag_wv
);
    logic [AW-1:0]    l1_addr;
    logic [AW-1:0]    l2_addr;
    logic [IDX_W-1:0] walk_low;
    logic [PPN_W-1:0] walk_page;
    logic             set_inv;
    logic             set_wv;

    xw_addr_gen #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_addr (
        .base_ppn (cfg_base_ppn),
        .new_vpn  (req_vpn),
        .walk_low (walk_low),
        .l2_page  (walk_page),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr)
    );

    xw_fsm #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_single    (cfg_single),
        .cfg_ill_en    (cfg_ill_en),
        .cfg_ill_ppn   (cfg_ill_ppn),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vpn       (req_vpn),
        .req_off       (req_off),
        .req_write     (req_write),
        .l1_addr       (l1_addr),
        .l2_addr       (l2_addr),
        .walk_low      (walk_low),
        .walk_page     (walk_page),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_ppn       (res_ppn),
        .res_paddr     (res_paddr),
        .res_writable  (res_writable),
        .res_size      (res_size),
        .res_inv       (res_inv),
        .res_wv        (res_wv)
    );

    // Fault events are taken from the single result cycle
    always_comb begin
        set_inv = res_valid && res_inv;
        set_wv  = res_valid && res_wv;
    end

    xw_sticky u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_inv  (set_inv),
        .set_wv   (set_wv),
        .clr_inv  (clr_inv_flag),
        .clr_wv   (clr_wv_flag),
        .flag_inv (flag_inv),
        .flag_wv  (flag_wv)
    );
endmodule

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;
    localparam int VPN_W = 24;
    localparam int PPN_W = 28;
    localparam int AW    = PPN_W + 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PPN_W-1:0]  cfg_base_ppn = '0;
    logic              cfg_single = 1'b0;
    logic              cfg_ill_en = 1'b0;
    logic [PPN_W-1:0]  cfg_ill_ppn = '0;
    logic              clr_inv_flag = 1'b0;
    logic              clr_wv_flag = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic [11:0]       req_off = '0;
    logic              req_write = 1'b0;
    logic              mem_req_valid;
    logic [AW-1:0]     mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              res_valid;
    logic [PPN_W-1:0]  res_ppn;
    logic [PPN_W+11:0] res_paddr;
    logic              res_writable;
    logic [1:0]        res_size;
    logic              res_inv;
    logic              res_wv;
    logic              flag_inv;
    logic              flag_wv;

    always #4 clk = ~clk;

    xlat_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W)) uut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lat = 0;

    logic [31:0] tmem [longint];
    longint      exp_addr_q[$];
    bit          pending = 0;
    string       cur_tag = "";
    longint      e_ppn, e_paddr;
    bit          e_wr_ok, e_inv, e_wv;
    int          e_size;

    function automatic logic [31:0] rd(longint a);
        if (tmem.exists(a)) return tmem[a];
        return 32'h0;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Behavioural memory with a configurable response delay
    bit     rpend = 0;
    int     rcnt = 0;
    longint raddr = 0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rpend) begin
            if (rcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(raddr);
                rpend = 0;
            end else begin
                rcnt--;
            end
        end
        if (rst_n && mem_req_valid) begin
            rpend = 1;
            rcnt  = lat;
            raddr = longint'(mem_req_addr);
        end
    end

    // Per-clock comparison of the memory port and the result port
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid) begin
                // R10: a walk in flight keeps the request side closed
                chk(req_ready == 1'b0, "R10", "req_ready while reading", longint'(req_ready), 0);
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, "R2/R3 unexpected read", "addr", longint'(mem_req_addr), -1);
                end else begin
                    longint ea;
                    ea = exp_addr_q.pop_front();
                    chk(longint'(mem_req_addr) == ea, cur_tag, "read address", longint'(mem_req_addr), ea);
                end
            end
            if (res_valid) begin
                if (!pending) begin
                    chk(1'b0, "R4", "unexpected res_valid", 1, 0);
                end else begin
                    chk(longint'(res_ppn) == e_ppn, cur_tag, "res_ppn", longint'(res_ppn), e_ppn);
                    chk(longint'(res_paddr) == e_paddr, cur_tag, "res_paddr", longint'(res_paddr), e_paddr);
                    chk(res_writable == e_wr_ok, cur_tag, "res_writable", longint'(res_writable), longint'(e_wr_ok));
                    chk(int'(res_size) == e_size, cur_tag, "res_size", longint'(res_size), longint'(e_size));
                    chk(res_inv == e_inv, cur_tag, "res_inv", longint'(res_inv), longint'(e_inv));
                    chk(res_wv == e_wv, cur_tag, "res_wv", longint'(res_wv), longint'(e_wv));
                    pending = 0;
                end
            end
        end
    end

    // One translation: build expectations from the requirements, drive, wait
    task automatic walk(input logic [VPN_W-1:0] vpn, input logic [11:0] off,
                        input bit wr, input string tag);
        longint a1, a2;
        logic [31:0] e1, leaf;
        int guard;
        a1 = (longint'(cfg_base_ppn) << 10) + longint'(vpn >> 10);
        exp_addr_q.push_back(a1);
        e1 = rd(a1);
        leaf = e1;
        if (e1[28]) begin
            a2 = (longint'(e1[27:0]) << 10) | longint'(vpn[9:0]);
            exp_addr_q.push_back(a2);
            leaf = rd(a2);
        end
        e_inv   = !leaf[28];
        e_ppn   = leaf[28] ? longint'(leaf[27:0]) : (cfg_ill_en ? longint'(cfg_ill_ppn) : 0);
        e_wr_ok = leaf[28] && leaf[29];
        e_size  = leaf[28] ? int'(leaf[31:30]) : 0;
        e_wv    = leaf[28] && wr && !leaf[29];
        e_paddr = (e_ppn << 12) | longint'(off);
        cur_tag = tag;
        pending = 1;
        req_vpn   = vpn;
        req_off   = off;
        req_write = wr;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (pending && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk(!pending, tag, "result arrived", longint'(pending), 0);
        pending = 0;
        @(negedge clk);
        chk(exp_addr_q.size() == 0, tag, "missing reads", exp_addr_q.size(), 0);
        exp_addr_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        chk(mem_req_valid == 0 && res_valid == 0, "R1", "busy in reset",
            longint'({mem_req_valid, res_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", longint'(req_ready), 1);
        chk(flag_inv == 0 && flag_wv == 0, "R1", "flags after reset",
            longint'({flag_inv, flag_wv}), 0);

        // Tables: base 0x100, one first-level entry with stray size/write bits
        cfg_base_ppn = 28'h100;
        tmem[64'h40048]  = 32'hF000_2000;
        tmem[64'h800345] = 32'hB00A_BCDE;
        tmem[64'h800346] = 32'h1000_0055;
        tmem[64'h800347] = 32'h2000_0099;

        lat = 0;
        walk(24'h012345, 12'h123, 1'b0, "R2 R3 R4 read mapped");
        lat = 2;
        walk(24'h012345, 12'hFFF, 1'b1, "R4 R7 write writable");
        chk(flag_wv == 0 && flag_inv == 0, "R7", "flags after clean walks",
            longint'({flag_inv, flag_wv}), 0);

        lat = 1;
        walk(24'h012346, 12'h010, 1'b0, "R7 read read-only");
        chk(flag_wv == 0, "R7", "flag_wv after read", longint'(flag_wv), 0);
        walk(24'h012346, 12'h020, 1'b1, "R7 write read-only");
        chk(flag_wv == 1, "R8", "flag_wv set", longint'(flag_wv), 1);

        cfg_ill_en = 1'b0;
        walk(24'h012347, 12'h030, 1'b1, "R6 invalid leaf no redirect");
        chk(flag_inv == 1, "R8", "flag_inv set", longint'(flag_inv), 1);
        chk(flag_wv == 1, "R8", "flag_wv held", longint'(flag_wv), 1);

        cfg_ill_en = 1'b1;
        cfg_ill_ppn = 28'h0000777;
        lat = 3;
        walk(24'h012347, 12'h040, 1'b0, "R6 invalid leaf redirect");
        walk(24'h013000, 12'h050, 1'b1, "R5 invalid first level");

        // R8: clearing each flag
        clr_inv_flag = 1'b1;
        @(negedge clk);
        clr_inv_flag = 1'b0;
        chk(flag_inv == 0, "R8", "flag_inv cleared", longint'(flag_inv), 0);
        chk(flag_wv == 1, "R8", "flag_wv untouched by other clear", longint'(flag_wv), 1);
        clr_wv_flag = 1'b1;
        @(negedge clk);
        clr_wv_flag = 1'b0;
        chk(flag_wv == 0, "R8", "flag_wv cleared", longint'(flag_wv), 0);

        // R2: biased base with a carrying add
        cfg_base_ppn = 28'h3;
        tmem[64'h4BFF]  = 32'h1000_0300;
        tmem[64'hC0000] = 32'h5123_4567;
        lat = 0;
        walk(24'hFFFC00, 12'hABC, 1'b0, "R2 biased base");

        // R9: single-table mode blocks requests
        cfg_single = 1'b1;
        req_vpn = 24'h012345;
        req_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(req_ready == 0, "R9", "req_ready in single mode", longint'(req_ready), 0);
        end
        req_valid = 1'b0;
        cfg_single = 1'b0;
        @(negedge clk);
        chk(req_ready == 1, "R9", "req_ready after single mode", longint'(req_ready), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule